// File: doc/BRIEF.md
# Single-Cycle Register-Transfer Datapath

This block carries out one register-transfer micro-operation per clock. It has a file of four general registers. Two combinational read ports feed an operand A bus and an operand B bus. The B operand can be replaced by a constant supplied from outside. A function unit then produces an arithmetic, bitwise or shift result. A write-back multiplexer picks either that result or an external data word, and the chosen value is stored into one destination register at the next rising clock edge.

A flat control word sets every transfer. Its fields are the two read selects, the B-source choice, a 4-bit function code, the write-back source, the destination select and a write enable. So a transfer such as "R1 gets R2 plus R3" takes exactly one cycle. The A bus is exported as an address, and the B bus is exported as outgoing data. Overflow, carry, negative and zero flags describe the function-unit result of the current cycle. The sequencer that produces the control words sits outside this block.

Top module: `regxfer_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers are cleared to zero. Afterwards every register reads back zero on both buses.
- R2: `addr_out` always shows the register numbered by `a_sel`, combinationally.
- R3: With `b_src`=0, `data_out` shows the register numbered by `b_sel`. With `b_src`=1, it shows `const_in`.
- R4: Function codes 0000–0111 are arithmetic. The result is A + Y + `fsel[0]`, where Y is chosen by `fsel[2:1]`: 00 gives zero, 01 gives B, 10 gives the bitwise inverse of B, and 11 gives all ones. So 0101 is A−B and 0110 is A−1.
- R5: Function codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R6: Function codes 1100 and 1111 pass B through unchanged. Code 1101 shifts B right by one bit and code 1110 shifts B left by one bit. In both shifts a zero fills the vacated bit.
- R7: With `d_src`=0, the function-unit result is written back. With `d_src`=1, `ext_data` is written back.
- R8: A register changes only at a rising edge where `wr_en`=1, and only the register numbered by `dst_sel` changes. With `wr_en`=0, no register changes.
- R9: When the destination is also a source, the read in that cycle returns the old value. The written value appears from the following cycle.
- R10: For arithmetic codes, `flag_c` is the carry out of the top bit and `flag_v` is the signed overflow. For bitwise and shift codes, both flags are 0.
- R11: `flag_n` equals the top bit of the function-unit result, and `flag_z` is 1 exactly when that result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 2 | Register driving the A bus |
| b_sel | input | 2 | Register offered to the B multiplexer |
| b_src | input | 1 | 0: register on the B bus, 1: `const_in` |
| const_in | input | WIDTH | External constant operand |
| fsel | input | 4 | Function code |
| d_src | input | 1 | 0: function result written back, 1: `ext_data` |
| ext_data | input | WIDTH | External write-back data |
| dst_sel | input | 2 | Destination register |
| wr_en | input | 1 | Write enable |
| addr_out | output | WIDTH | A bus |
| data_out | output | WIDTH | B bus |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |

## Verification
Several behaviours are checked by assertions on every clock. A disabled write leaves the register file untouched. An enabled write lands the presented value in the addressed register. A register read in the cycle after a write to it returns the new value. Carry and overflow stay low for non-arithmetic codes, and zero and negative never hold together. The exact result of every function code, including carry and overflow at the signed and unsigned wrap points, the choice of write-back source and operand source, and the clearing done by reset can only be shown by the bench's scenarios. It loads operands, runs each code and reads the written-back result on the A bus.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  // Function-code groups, decoded from fsel[3:2]
  localparam logic [1:0] GRP_LOGIC = 2'b10;
  localparam logic [1:0] GRP_SHIFT = 2'b11;

  // Shifter sub-codes, fsel[1:0]
  localparam logic [1:0] SH_PASS  = 2'b00;
  localparam logic [1:0] SH_RIGHT = 2'b01;
  localparam logic [1:0] SH_LEFT  = 2'b10;

  // Bitwise sub-codes, fsel[1:0]
  localparam logic [1:0] LG_AND = 2'b00;
  localparam logic [1:0] LG_OR  = 2'b01;
  localparam logic [1:0] LG_XOR = 2'b10;

endpackage

// File: rtl/regxfer_regfile.sv
module regxfer_regfile #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rd_a_sel,
  input  logic [SEL_W-1:0] rd_b_sel,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_a,
  output logic [WIDTH-1:0] rd_b
);

  logic [NREGS-1:0][WIDTH-1:0] rf_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic             ld;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] q_d;

    assign ld = wr_en && (wr_sel == SEL_W'(i));

    always_comb begin
      q_d = q;
      if (ld) q_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_d;
    end

    assign rf_q[i] = q;
  end

  assign rd_a = rf_q[rd_a_sel];
  assign rd_b = rf_q[rd_b_sel];

  // R8: no enable, no change anywhere in the file
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rf_q));

  // R8: an enabled write lands in the addressed register
  a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rf_q[$past(wr_sel)] == $past(wr_data));

endmodule

// File: rtl/regxfer_alu.sv
module regxfer_alu
  import regxfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       fsel,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);

  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] lres;

  always_comb begin
    unique case (fsel[2:1])
      2'b00:   y = '0;
      2'b01:   y = b;
      2'b10:   y = ~b;
      default: y = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, fsel[0]};

  always_comb begin
    unique case (fsel[1:0])
      LG_AND:  lres = a & b;
      LG_OR:   lres = a | b;
      LG_XOR:  lres = a ^ b;
      default: lres = ~a;
    endcase
  end

  always_comb begin
    if (fsel[3]) begin
      res   = lres;
      carry = 1'b0;
      ovf   = 1'b0;
    end else begin
      res   = sum[WIDTH-1:0];
      carry = sum[WIDTH];
      ovf   = (a[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
  end

endmodule

// File: rtl/regxfer_shifter.sv
module regxfer_shifter
  import regxfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       hsel,
  output logic [WIDTH-1:0] h
);

  always_comb begin
    unique case (hsel)
      SH_RIGHT: h = {1'b0, b[WIDTH-1:1]};
      SH_LEFT:  h = {b[WIDTH-2:0], 1'b0};
      default:  h = b;
    endcase
  end

endmodule

// File: rtl/regxfer_datapath.sv
module regxfer_datapath
  import regxfer_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] a_sel,
  input  logic [SEL_W-1:0] b_sel,
  input  logic             b_src,
  input  logic [WIDTH-1:0] const_in,
  input  logic [3:0]       fsel,
  input  logic             d_src,
  input  logic [WIDTH-1:0] ext_data,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic             wr_en,
  output logic [WIDTH-1:0] addr_out,
  output logic [WIDTH-1:0] data_out,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_z
);

  logic [WIDTH-1:0] a_bus, reg_b, b_bus;
  logic [WIDTH-1:0] alu_res, sh_res, fu_res, d_bus;
  logic             alu_c, alu_v, use_shift;

  regxfer_regfile #(.WIDTH(WIDTH), .NREGS(NREGS)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_sel (a_sel),
    .rd_b_sel (b_sel),
    .wr_sel   (dst_sel),
    .wr_en    (wr_en),
    .wr_data  (d_bus),
    .rd_a     (a_bus),
    .rd_b     (reg_b)
  );

  assign b_bus = b_src ? const_in : reg_b;

  regxfer_alu #(.WIDTH(WIDTH)) u_alu (
    .a     (a_bus),
    .b     (b_bus),
    .fsel  (fsel),
    .res   (alu_res),
    .carry (alu_c),
    .ovf   (alu_v)
  );

  regxfer_shifter #(.WIDTH(WIDTH)) u_sh (
    .b    (b_bus),
    .hsel (fsel[1:0]),
    .h    (sh_res)
  );

  assign use_shift = (fsel[3:2] == GRP_SHIFT);
  assign fu_res    = use_shift ? sh_res : alu_res;
  assign d_bus     = d_src ? ext_data : fu_res;

  assign addr_out = a_bus;
  assign data_out = b_bus;
  assign flag_c   = use_shift ? 1'b0 : alu_c;
  assign flag_v   = use_shift ? 1'b0 : alu_v;
  assign flag_n   = fu_res[WIDTH-1];
  assign flag_z   = (fu_res == '0);

  // R9: a register written last cycle reads back the written value now
  a_r9_new_value_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (a_sel != $past(dst_sel)) || (addr_out == $past(d_bus)));

  // R10: carry and overflow stay low outside the arithmetic codes
  a_r10_no_arith_flags: assert property (@(posedge clk) disable iff (!rst_n)
    fsel[3] |-> !flag_c && !flag_v);

  // R11: zero and negative are mutually exclusive
  a_r11_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);

endmodule

// File: tb/regxfer_datapath_test.sv
module regxfer_datapath_test;

  localparam int W = 8;

  typedef struct packed {
    logic [3:0]   fs;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] r;
    logic         c;
    logic         v;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VEC [NVEC] = '{
    '{4'b0000, 8'h5A, 8'h00, 8'h5A, 1'b0, 1'b0},   // R4 transfer A
    '{4'b0001, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0},   // R4 A+1 wraps
    '{4'b0010, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b1},   // R4 A+B signed overflow
    '{4'b0011, 8'h80, 8'hFF, 8'h80, 1'b1, 1'b0},   // R4 A+B+1
    '{4'b0100, 8'h10, 8'h01, 8'h0E, 1'b1, 1'b0},   // R4 A+~B
    '{4'b0101, 8'h05, 8'h07, 8'hFE, 1'b0, 1'b0},   // R4 A-B borrow
    '{4'b0101, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1},   // R4 A-B overflow
    '{4'b0110, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0},   // R4 A-1
    '{4'b0111, 8'h3C, 8'h00, 8'h3C, 1'b1, 1'b0},   // R4 A+ones+1
    '{4'b1000, 8'hF0, 8'h3C, 8'h30, 1'b0, 1'b0},   // R5 AND
    '{4'b1001, 8'hF0, 8'h0F, 8'hFF, 1'b0, 1'b0},   // R5 OR
    '{4'b1010, 8'hAA, 8'hFF, 8'h55, 1'b0, 1'b0},   // R5 XOR
    '{4'b1011, 8'h0F, 8'h00, 8'hF0, 1'b0, 1'b0},   // R5 NOT A
    '{4'b1100, 8'h00, 8'h81, 8'h81, 1'b0, 1'b0},   // R6 pass B
    '{4'b1101, 8'h00, 8'h81, 8'h40, 1'b0, 1'b0},   // R6 shift right
    '{4'b1110, 8'h00, 8'h81, 8'h02, 1'b0, 1'b0},   // R6 shift left
    '{4'b1111, 8'hFF, 8'h81, 8'h81, 1'b0, 1'b0}    // R6 pass B (alt)
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   a_sel, b_sel, dst_sel;
  logic         b_src, d_src, wr_en;
  logic [W-1:0] const_in, ext_data;
  logic [3:0]   fsel;
  logic [W-1:0] addr_out, data_out;
  logic         flag_v, flag_c, flag_n, flag_z;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  regxfer_datapath #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel), .b_src(b_src),
    .const_in(const_in), .fsel(fsel), .d_src(d_src), .ext_data(ext_data),
    .dst_sel(dst_sel), .wr_en(wr_en), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] idx, input logic [W-1:0] val);
    @(negedge clk);
    d_src = 1'b1; ext_data = val; dst_sel = idx; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; a_sel = '0; b_sel = '0; dst_sel = '0;
    b_src = 1'b0; d_src = 1'b0; wr_en = 1'b0;
    const_in = '0; ext_data = '0; fsel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every register reads zero after reset, through both buses
    for (int i = 0; i < 4; i++) begin
      a_sel = 2'(i); b_sel = 2'(i); #2;
      chk("R1 reset A bus", addr_out, 0);
      chk("R1 reset B bus", data_out, 0);
    end

    // Vector table: R0 gets A, const supplies B, result written to R1
    for (int k = 0; k < NVEC; k++) begin
      load(2'd0, VEC[k].a);
      a_sel = 2'd0; b_src = 1'b1; const_in = VEC[k].b; fsel = VEC[k].fs;
      d_src = 1'b0; dst_sel = 2'd1; wr_en = 1'b1;
      #2;
      chk("R10 carry", flag_c, VEC[k].c);
      chk("R10 overflow", flag_v, VEC[k].v);
      chk("R11 negative", flag_n, VEC[k].r[W-1]);
      chk("R11 zero", flag_z, VEC[k].r == 0);
      chk("R3 constant on B bus", data_out, VEC[k].b);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; a_sel = 2'd1; #2;
      chk(VEC[k].fs[3] ? (VEC[k].fs[2] ? "R6 shift result" : "R5 logic result")
                       : "R4 arith result", addr_out, VEC[k].r);
    end

    // R7/R2: external data lands in each register independently
    load(2'd0, 8'h11); load(2'd1, 8'h22); load(2'd2, 8'h33); load(2'd3, 8'h44);
    for (int i = 0; i < 4; i++) begin
      a_sel = 2'(i); #2;
      chk("R7 ext write / R2 A select", addr_out, 8'h11 * (i + 1));
    end

    // R3: register source on B bus
    b_src = 1'b0; b_sel = 2'd3; #2;
    chk("R3 register on B bus", data_out, 8'h44);

    // R8: wr_en low leaves everything unchanged
    @(negedge clk);
    d_src = 1'b1; ext_data = 8'hEE; dst_sel = 2'd2; wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    a_sel = 2'd2; #2;
    chk("R8 disabled write ignored", addr_out, 8'h33);

    // R8: only the destination changes
    load(2'd2, 8'h99);
    a_sel = 2'd1; #2; chk("R8 neighbour untouched", addr_out, 8'h22);
    a_sel = 2'd3; #2; chk("R8 neighbour untouched", addr_out, 8'h44);

    // R9: R2 <- R2 + R3; old value in the write cycle, new one after
    @(negedge clk);
    a_sel = 2'd2; b_sel = 2'd3; b_src = 1'b0; fsel = 4'b0010;
    d_src = 1'b0; dst_sel = 2'd2; wr_en = 1'b1;
    #2;
    chk("R9 old value during write", addr_out, 8'h99);
    @(posedge clk); #1;
    chk("R9 old value just after edge is replaced", addr_out, 8'hDD);
    @(negedge clk);
    wr_en = 1'b0; #2;
    chk("R9 new value next cycle", addr_out, 8'hDD);

    // R7: d_src=0 writes the function result, not ext_data
    @(negedge clk);
    ext_data = 8'h00; b_src = 1'b1; const_in = 8'h01; fsel = 4'b0010;
    a_sel = 2'd3; d_src = 1'b0; dst_sel = 2'd0; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; a_sel = 2'd0; #2;
    chk("R7 function result selected", addr_out, 8'h45);

    // R1: reset in mid-run clears written registers
    @(negedge clk) rst_n = 1'b0;
    #2;
    a_sel = 2'd2; #1; chk("R1 mid-run reset", addr_out, 0);
    @(negedge clk) rst_n = 1'b1;
    a_sel = 2'd3; #2; chk("R1 mid-run reset", addr_out, 0);

    summary();
  end

endmodule